// File: doc/BRIEF.md
# Serial Bus Host Register Front End

This block is the register face that a host processor sees when it drives a single-master serial peripheral bus. Every bus transfer moves one byte. The host writes a command word that names a read or a write, gives the low address byte, and for a write gives the data byte. It then polls a status word until the transfer is over. The byte fetched by a read is collected from a read-data register.

The bus address is 15 bits wide. The low eight bits come with each command word. The upper seven bits come from a separately held mode register, so a run of accesses to one page of the peripheral only has to rewrite the command word. The low four bits of the mode register are plain mode bits and play no part in the address.

Toward the bus the block has an abstract transaction port. A one-cycle request carries the direction, the address and the write byte. Some time later a one-cycle completion returns, carrying the read byte. The serial wire encoding behind that port is handled elsewhere.

Top module: `serbus_regfront`

## Requirements
- R1: After reset the status register (offset 0x14) reads 0x2: READY (bit 1) set, MACHINE_BUSY (bit 0) clear, RD_READY (bit 2) clear. No request is issued.
- R2: A write to the command register (offset 0x08) while READY is set causes one request pulse in the next cycle, and only one. The request carries read when word bit 24 is 1 and write when it is 0. It carries address bits 7:0 from word bits 23:16 and the write byte from word bits 7:0. From the next cycle the status reads 0x1.
- R3: Request address bits 14:8 equal mode register bits 10:4 and address bit 15 is 0. Mode register bits 3:0 have no effect on the address.
- R4: The mode register (offset 0x1C) reads back bits 10:0 as last written, with all higher bits reading zero.
- R5: A command write while READY is clear is ignored. No request follows, and the transfer already in flight keeps its direction and address.
- R6: On completion of a write transfer, MACHINE_BUSY clears and READY sets, while RD_READY stays clear. The status reads 0x2.
- R7: On completion of a read transfer, the returned byte is latched and the status reads 0x6. The read-data register (offset 0x10) then returns the byte in bits 7:0 and zero in bits 31:8.
- R8: Reading the read-data register clears RD_READY. A later read of that register still returns the same byte.
- R9: An accepted command write clears RD_READY even if the previous read byte was never collected.
- R10: A host read returns its value on host_rdata in the cycle after host_rd. The command offset and every unmapped offset read as zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock |
| rst_n | input | 1 | Active-low synchronous reset |
| host_wr | input | 1 | Host register write strobe |
| host_rd | input | 1 | Host register read strobe |
| host_ofs | input | OFS_W | Register byte offset |
| host_wdata | input | 32 | Host write data |
| host_rdata | output | 32 | Host read data, valid the cycle after host_rd |
| bus_req | output | 1 | One-cycle transfer request |
| bus_rnw | output | 1 | Transfer direction, 1 = read |
| bus_addr | output | 16 | Transfer address |
| bus_wdata | output | 8 | Byte to write |
| bus_done | input | 1 | One-cycle transfer completion |
| bus_rdata | input | 8 | Byte returned with completion of a read |

## Verification
The bench builds the block with its default register offsets. Its stand-in bus slave answers after a latency that is set at run time. A long latency of 300 cycles leaves a wide busy window, in which rejected command writes are tried and the status is sampled mid-transfer. A one-cycle latency brings completion right behind the request and checks that the status and read byte settle with no gap. The slave returns a byte computed from the address, so the bench can check every read against a value it works out itself.

// File: rtl/serbus_regfront.sv
module serbus_regfront #(
  parameter int OFS_W = 8,
  parameter logic [OFS_W-1:0] CMD_OFS  = 8'h08,
  parameter logic [OFS_W-1:0] RD_OFS   = 8'h10,
  parameter logic [OFS_W-1:0] STAT_OFS = 8'h14,
  parameter logic [OFS_W-1:0] MODE_OFS = 8'h1C
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             host_wr,
  input  logic             host_rd,
  input  logic [OFS_W-1:0] host_ofs,
  input  logic [31:0]      host_wdata,
  output logic [31:0]      host_rdata,
  output logic             bus_req,
  output logic             bus_rnw,
  output logic [15:0]      bus_addr,
  output logic [7:0]       bus_wdata,
  input  logic             bus_done,
  input  logic [7:0]       bus_rdata
);

  logic        busy, rd_ready;
  logic [10:0] mode_q;
  logic [7:0]  byte_q;
  logic [31:0] rd_mux;

  wire cmd_take = host_wr && (host_ofs == CMD_OFS) && !busy;
  wire finish   = bus_done && busy;
  wire rd_pop   = host_rd && (host_ofs == RD_OFS);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      busy      <= 1'b0;
      rd_ready  <= 1'b0;
      mode_q    <= '0;
      byte_q    <= '0;
      bus_req   <= 1'b0;
      bus_rnw   <= 1'b0;
      bus_addr  <= '0;
      bus_wdata <= '0;
    end else begin
      bus_req <= cmd_take;
      if (host_wr && host_ofs == MODE_OFS) mode_q <= host_wdata[10:0];
      if (cmd_take) begin
        busy      <= 1'b1;
        rd_ready  <= 1'b0;
        bus_rnw   <= host_wdata[24];
        bus_addr  <= {1'b0, mode_q[10:4], host_wdata[23:16]};
        bus_wdata <= host_wdata[7:0];
      end else if (finish) begin
        busy <= 1'b0;
        if (bus_rnw) begin
          byte_q   <= bus_rdata;
          rd_ready <= 1'b1;
        end
      end else if (rd_pop) begin
        rd_ready <= 1'b0;
      end
    end
  end

  always_comb begin
    rd_mux = '0;
    if (host_ofs == RD_OFS)   rd_mux = {24'h0, byte_q};
    if (host_ofs == STAT_OFS) rd_mux = {29'h0, rd_ready, !busy, busy};
    if (host_ofs == MODE_OFS) rd_mux = {21'h0, mode_q};
  end

  always_ff @(posedge clk) begin
    if (!rst_n)       host_rdata <= '0;
    else if (host_rd) host_rdata <= rd_mux;
    else              host_rdata <= '0;
  end

endmodule

// File: rtl/serbus_regfront_chk.sv
module serbus_regfront_chk #(
  parameter int OFS_W = 8,
  parameter logic [OFS_W-1:0] CMD_OFS = 8'h08,
  parameter logic [OFS_W-1:0] RD_OFS  = 8'h10
) (
  input logic             clk,
  input logic             rst_n,
  input logic             host_wr,
  input logic             host_rd,
  input logic [OFS_W-1:0] host_ofs,
  input logic             bus_req,
  input logic             bus_rnw,
  input logic [15:0]      bus_addr,
  input logic             bus_done,
  input logic [7:0]       bus_rdata,
  input logic             busy,
  input logic             rd_ready,
  input logic [7:0]       byte_q
);

  a_r2_single_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    bus_req |=> !bus_req);

  a_r2_accept_issues: assert property (@(posedge clk) disable iff (!rst_n)
    (host_wr && host_ofs == CMD_OFS && !busy) |=> (bus_req && busy));

  a_r5_busy_ignored: assert property (@(posedge clk) disable iff (!rst_n)
    (host_wr && host_ofs == CMD_OFS && busy && !bus_done) |=>
      (!bus_req && $stable(bus_addr) && $stable(bus_rnw)));

  a_r3_top_bit_zero: assert property (@(posedge clk) disable iff (!rst_n)
    bus_req |-> !bus_addr[15]);

  a_r6_done_frees: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_done && busy) |=> !busy);

  a_r7_read_latch: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_done && busy && bus_rnw) |=> (rd_ready && byte_q == $past(bus_rdata)));

  a_r8_pop_clears: assert property (@(posedge clk) disable iff (!rst_n)
    (host_rd && host_ofs == RD_OFS && !(bus_done && busy)) |=> !rd_ready);

  a_r9_new_cmd_clears: assert property (@(posedge clk) disable iff (!rst_n)
    bus_req |-> !rd_ready);

endmodule

bind serbus_regfront serbus_regfront_chk #(
  .OFS_W(OFS_W), .CMD_OFS(CMD_OFS), .RD_OFS(RD_OFS)
) chk_i (
  .clk(clk), .rst_n(rst_n), .host_wr(host_wr), .host_rd(host_rd),
  .host_ofs(host_ofs), .bus_req(bus_req), .bus_rnw(bus_rnw),
  .bus_addr(bus_addr), .bus_done(bus_done), .bus_rdata(bus_rdata),
  .busy(busy), .rd_ready(rd_ready), .byte_q(byte_q)
);

// File: tb/serbus_regfront_tb.sv
module serbus_regfront_tb_top;
  localparam int SLOW_LAT = 300;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        host_wr = 1'b0, host_rd = 1'b0;
  logic [7:0]  host_ofs = '0;
  logic [31:0] host_wdata = '0, host_rdata;
  logic        bus_req, bus_rnw, bus_done = 1'b0;
  logic [15:0] bus_addr;
  logic [7:0]  bus_wdata, bus_rdata = '0;

  int n_cmp = 0, n_bad = 0;
  int lat = SLOW_LAT;
  int cnt = 0;
  logic [15:0] slv_addr = '0;
  logic [24:0] exp_q[$];

  always #5 clk = ~clk;

  serbus_regfront dut_i (
    .clk(clk), .rst_n(rst_n), .host_wr(host_wr), .host_rd(host_rd),
    .host_ofs(host_ofs), .host_wdata(host_wdata), .host_rdata(host_rdata),
    .bus_req(bus_req), .bus_rnw(bus_rnw), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_done(bus_done), .bus_rdata(bus_rdata)
  );

  function automatic logic [7:0] slv_byte(input logic [15:0] a);
    return a[7:0] ^ {1'b0, a[14:8]} ^ 8'hA5;
  endfunction

  always @(posedge clk) begin
    bus_done <= 1'b0;
    if (cnt > 0) begin
      cnt <= cnt - 1;
      if (cnt == 1) begin
        bus_done  <= 1'b1;
        bus_rdata <= slv_byte(slv_addr);
      end
    end else if (bus_req) begin
      cnt      <= lat;
      slv_addr <= bus_addr;
    end
  end

  always @(posedge clk) begin
    if (rst_n && bus_req) begin
      n_cmp++;
      if (exp_q.size() == 0) begin
        n_bad++;
        $display("FAIL R5 unexpected request: got %h expected none",
                 {bus_rnw, bus_addr, bus_wdata});
      end else begin
        logic [24:0] e;
        e = exp_q.pop_front();
        if ({bus_rnw, bus_addr, bus_wdata} !== e) begin
          n_bad++;
          $display("FAIL R2/R3 request: got %h expected %h",
                   {bus_rnw, bus_addr, bus_wdata}, e);
        end
      end
    end
  end

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: got %h expected %h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [7:0] ofs, input logic [31:0] d);
    @(negedge clk);
    host_wr = 1'b1; host_ofs = ofs; host_wdata = d;
    @(negedge clk);
    host_wr = 1'b0;
  endtask

  task automatic rd(input logic [7:0] ofs, output logic [31:0] d);
    @(negedge clk);
    host_rd = 1'b1; host_ofs = ofs;
    @(negedge clk);
    host_rd = 1'b0;
    d = host_rdata;
  endtask

  task automatic wait_idle();
    logic [31:0] s;
    for (int i = 0; i < 2000; i++) begin
      rd(8'h14, s);
      if (!s[0]) return;
    end
    check("R6 idle timeout", 32'h1, 32'h0);
  endtask

  task automatic issue(input logic rnw, input logic [15:0] a, input logic [7:0] d);
    exp_q.push_back({rnw, a, d});
    wr(8'h08, {7'h0, rnw, a[7:0], 8'h00, d});
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_bad++;
    $display("FAIL watchdog expired");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    logic [31:0] v;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    check("R1 no request", {31'h0, bus_req}, 32'h0);
    rd(8'h14, v); check("R1 reset status", v, 32'h2);

    wr(8'h1C, 32'h0000_07F5); rd(8'h1C, v); check("R4 mode readback", v, 32'h7F5);
    wr(8'h1C, 32'hFFFF_FFFF); rd(8'h1C, v); check("R4 upper bits zero", v, 32'h7FF);

    lat = SLOW_LAT;
    wr(8'h1C, 32'h125);
    issue(1'b0, 16'h12AB, 8'h3C);
    rd(8'h14, v); check("R2 busy status", v, 32'h1);
    wr(8'h08, 32'h01FF_0011);
    rd(8'h14, v); check("R5 still busy after ignored write", v, 32'h1);
    wait_idle();
    rd(8'h14, v); check("R6 write done status", v, 32'h2);
    check("R5 no extra request queued", exp_q.size(), 0);

    wr(8'h1C, 32'h0A3);
    issue(1'b1, 16'h0A55, 8'h99);
    wait_idle();
    rd(8'h14, v); check("R7 read done status", v, 32'h6);
    rd(8'h10, v); check("R7 read byte", v, {24'h0, slv_byte(16'h0A55)});
    rd(8'h14, v); check("R8 rd_ready cleared", v, 32'h2);
    rd(8'h10, v); check("R8 byte kept", v, {24'h0, slv_byte(16'h0A55)});

    lat = 1;
    wr(8'h1C, 32'h12F);
    issue(1'b1, 16'h1234, 8'h00);
    wait_idle();
    rd(8'h14, v); check("R3 fast read status", v, 32'h6);
    rd(8'h10, v); check("R3 fast read byte", v, {24'h0, slv_byte(16'h1234)});
    issue(1'b1, 16'h1277, 8'h00);
    wait_idle();
    lat = SLOW_LAT;
    issue(1'b0, 16'h1201, 8'h5A);
    rd(8'h14, v); check("R9 new command clears rd_ready", v, 32'h1);
    wait_idle();
    rd(8'h14, v); check("R9 status after write", v, 32'h2);

    lat = 1;
    wr(8'h1C, 32'h7F0);
    issue(1'b0, 16'h7FFF, 8'hE1);
    wait_idle();
    check("R3 max address consumed", exp_q.size(), 0);

    rd(8'h08, v); check("R10 command offset reads zero", v, 32'h0);
    rd(8'h00, v); check("R10 unmapped 0x00", v, 32'h0);
    rd(8'h18, v); check("R10 unmapped 0x18", v, 32'h0);
    @(negedge clk);
    check("R10 idle rdata", host_rdata, 32'h0);

    repeat (5) @(negedge clk);
    check("R2 all requests seen", exp_q.size(), 0);
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule